// File: doc/BRIEF.md
# Cartridge Bank Switching Mapper

This block sits between a game console's buses and the memories on a cartridge. It watches CPU writes to the upper half of CPU address space and stores bank numbers and a mirroring mode in a small set of registers. From those registers it builds the upper address lines for three targets: a program ROM of up to 256 KB, a character ROM of up to 256 KB, and the console's internal nametable RAM.

The CPU program space above 0x8000 is split into three windows. A switchable 16 KB window covers 0x8000–0xBFFF. A switchable 8 KB window covers 0xC000–0xDFFF. A fixed 8 KB window at 0xE000–0xFFFF always shows the last program bank. The picture unit's pattern space (0x0000–0x1FFF) is cut into eight 1 KB slots, and each slot has its own bank register. A strap input selects between two board wirings. On one of them, CPU address lines 0 and 1 reach the register decoder in swapped order.

Every address output is a combinational function of the current bus address and the register contents. A register write is taken on the clock edge that sees the write strobe high. The block never stalls the CPU, so there is no back-pressure: a write is accepted on the same cycle it is presented.

Top module: `bank_mapper`

## Requirements
- R1: After reset, every bank register holds zero and the mirroring mode is vertical (mode 0).
- R2: A write that decodes to page 0x8 stores data bits 3:0 as the 16 KB bank. For CPU 0x8000–0xBFFF, the program ROM address is {bank16[3:0], cpu_addr[13:0]}. Data bits 7:4 have no effect.
- R3: A write that decodes to page 0xC stores data bits 4:0 as the 8 KB bank. For CPU 0xC000–0xDFFF, the program ROM address is {bank8[4:0], cpu_addr[12:0]}.
- R4: For CPU 0xE000–0xFFFF, the program ROM address is {5'b11111, cpu_addr[12:0]}, whatever the register contents.
- R5: The program RAM enable is high exactly for CPU 0x6000–0x7FFF. The program ROM enable is high exactly for CPU 0x8000–0xFFFF.
- R6: Eight character registers are selected by page 0xD, offsets 0–3 (slots 0–3), and page 0xE, offsets 0–3 (slots 4–7). For picture-unit addresses below 0x2000, the character ROM address is {slot[ppu_addr[12:10]], ppu_addr[9:0]}, and the character ROM enable is high exactly there.
- R7: A write to page 0xB, offset 3, stores data bits 3:2 as the mirroring mode. The nametable A10 output equals ppu_addr[10] in mode 0, ppu_addr[11] in mode 1, 0 in mode 2 and 1 in mode 3.
- R8: Decode looks only at address bits 15:12 and 1:0, so every address with the same (addr AND 0xF003) reaches the same register. For example, 0xDE6A writes character slot 2.
- R9: With the variant strap high, CPU A0 and A1 are exchanged before decode. Offset 1 then reaches the offset-2 register and offset 2 reaches the offset-1 register.
- R10: Writes to pages 0x9, 0xA and 0xF, to page 0xB offsets 0–2, and to any address below 0x8000 change no register.
- R11: A register changes only on a rising clock edge where the write strobe is high. Before that edge the outputs still reflect the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| variant_swap | input | 1 | Board strap; high exchanges A0 and A1 for decode |
| ppu_addr | input | 14 | Picture-unit address bus |
| prg_rom_addr | output | 18 | Program ROM address |
| prg_rom_en | output | 1 | Program ROM select |
| prg_ram_en | output | 1 | Program RAM select |
| chr_rom_addr | output | 18 | Character ROM address |
| chr_rom_en | output | 1 | Character ROM select |
| nt_a10 | output | 1 | Nametable RAM address line 10 |

## Verification
Some properties are checked on every cycle:
- The assertions confirm that at most one register is selected per write.
- Registers not addressed on a cycle keep their value.
- A selected register loads the written bits one cycle later.
- The fixed window always carries all-ones bank bits, and the single-screen lower mode drives A10 low.
- The RAM and ROM selects never overlap.

Other behaviour needs the bench's scenarios:
- the exact address mapping for chosen bank values;
- the address-mask aliasing;
- the strap's exchange of offsets 1 and 2;
- that writes to audio or interrupt pages leave every register intact;
- that the output stays at the old value until the strobed edge.

// File: rtl/mapper_pkg.sv
`timescale 1ns/1ps
package mapper_pkg;
  localparam int CPU_AW     = 16;
  localparam int PPU_AW     = 14;
  localparam int CHR_SLOTS  = 8;
  localparam int CHR_SEL_W  = $clog2(CHR_SLOTS);
  localparam int SLOT_OFF_W = 10;

  typedef enum logic [1:0] {
    MIR_VERT = 2'd0,
    MIR_HORZ = 2'd1,
    MIR_LOW  = 2'd2,
    MIR_HIGH = 2'd3
  } mirror_t;

  typedef struct packed {
    logic                 prg16;
    logic                 prg8;
    logic                 mirror;
    logic [CHR_SLOTS-1:0] chr;
  } wsel_t;
endpackage

// File: rtl/mapper_reg_decode.sv
`timescale 1ns/1ps
module mapper_reg_decode
  import mapper_pkg::*;
(
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic              variant_swap,
  output wsel_t             wsel
);
  logic [1:0] low_off;
  logic [3:0] page;

  always_comb begin
    low_off = variant_swap ? {cpu_addr[0], cpu_addr[1]} : cpu_addr[1:0];
    page    = cpu_addr[CPU_AW-1:CPU_AW-4];
    wsel    = '0;
    if (cpu_we) begin
      case (page)
        4'h8: wsel.prg16  = 1'b1;
        4'hB: wsel.mirror = (low_off == 2'd3);
        4'hC: wsel.prg8   = 1'b1;
        4'hD: wsel.chr[{1'b0, low_off}] = 1'b1;
        4'hE: wsel.chr[{1'b1, low_off}] = 1'b1;
        default: wsel = '0;
      endcase
    end
  end
endmodule

// File: rtl/mapper_bank_regs.sv
`timescale 1ns/1ps
module mapper_bank_regs
  import mapper_pkg::*;
#(
  parameter int PRG16_BITS = 4,
  parameter int CHR_BITS   = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  wsel_t                               wsel,
  input  logic [7:0]                          wdata,
  output logic [PRG16_BITS-1:0]               prg16_bank,
  output logic [PRG16_BITS:0]                 prg8_bank,
  output logic [CHR_SLOTS-1:0][CHR_BITS-1:0]  chr_bank,
  output mirror_t                             mirror
);
  localparam int PRG8_BITS = PRG16_BITS + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg16_bank <= '0;
      prg8_bank  <= '0;
      mirror     <= MIR_VERT;
    end else begin
      if (wsel.prg16)  prg16_bank <= wdata[PRG16_BITS-1:0];
      if (wsel.prg8)   prg8_bank  <= wdata[PRG8_BITS-1:0];
      if (wsel.mirror) mirror     <= mirror_t'(wdata[3:2]);
    end
  end

  // R10: an unaddressed 16 KB bank keeps its value
  p_prg16_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wsel.prg16 |=> $stable(prg16_bank));
  // R3: a selected 8 KB bank loads the written bits
  p_prg8_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wsel.prg8 |=> (prg8_bank == $past(wdata[PRG8_BITS-1:0])));
  // R7: mirroring mode loads data bits 3:2
  p_mirror_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wsel.mirror |=> (mirror == mirror_t'($past(wdata[3:2]))));

  for (genvar g = 0; g < CHR_SLOTS; g++) begin : g_chr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          chr_bank[g] <= '0;
      else if (wsel.chr[g]) chr_bank[g] <= wdata[CHR_BITS-1:0];
    end
    // R6: a selected slot loads the write data; others hold
    p_chr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wsel.chr[g] |=> (chr_bank[g] == $past(wdata[CHR_BITS-1:0])));
    p_chr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wsel.chr[g] |=> $stable(chr_bank[g]));
  end
endmodule

// File: rtl/mapper_addr_xlate.sv
`timescale 1ns/1ps
module mapper_addr_xlate
  import mapper_pkg::*;
#(
  parameter int PRG16_BITS = 4,
  parameter int CHR_BITS   = 8
) (
  input  logic [CPU_AW-1:0]                   cpu_addr,
  input  logic [PPU_AW-1:0]                   ppu_addr,
  input  logic [PRG16_BITS-1:0]               prg16_bank,
  input  logic [PRG16_BITS:0]                 prg8_bank,
  input  logic [CHR_SLOTS-1:0][CHR_BITS-1:0]  chr_bank,
  input  mirror_t                             mirror,
  output logic [PRG16_BITS+13:0]              prg_rom_addr,
  output logic                                prg_rom_en,
  output logic                                prg_ram_en,
  output logic [CHR_BITS+SLOT_OFF_W-1:0]      chr_rom_addr,
  output logic                                chr_rom_en,
  output logic                                nt_a10
);
  localparam int PRG8_BITS = PRG16_BITS + 1;

  logic [CHR_SEL_W-1:0] slot;

  always_comb begin
    prg_rom_en = cpu_addr[15];
    prg_ram_en = (cpu_addr[15:13] == 3'b011);
    case (cpu_addr[14:13])
      2'b00, 2'b01: prg_rom_addr = {prg16_bank, cpu_addr[13:0]};
      2'b10:        prg_rom_addr = {prg8_bank, cpu_addr[12:0]};
      default:      prg_rom_addr = {{PRG8_BITS{1'b1}}, cpu_addr[12:0]};
    endcase
  end

  always_comb begin
    slot         = ppu_addr[SLOT_OFF_W+CHR_SEL_W-1:SLOT_OFF_W];
    chr_rom_en   = ~ppu_addr[13];
    chr_rom_addr = {chr_bank[slot], ppu_addr[SLOT_OFF_W-1:0]};
    case (mirror)
      MIR_VERT: nt_a10 = ppu_addr[10];
      MIR_HORZ: nt_a10 = ppu_addr[11];
      MIR_LOW:  nt_a10 = 1'b0;
      default:  nt_a10 = 1'b1;
    endcase
  end
endmodule

// File: rtl/bank_mapper.sv
`timescale 1ns/1ps
module bank_mapper
  import mapper_pkg::*;
#(
  parameter int PRG16_BITS = 4,
  parameter int CHR_BITS   = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [15:0]                       cpu_addr,
  input  logic [7:0]                        cpu_data,
  input  logic                              cpu_we,
  input  logic                              variant_swap,
  input  logic [13:0]                       ppu_addr,
  output logic [PRG16_BITS+13:0]            prg_rom_addr,
  output logic                              prg_rom_en,
  output logic                              prg_ram_en,
  output logic [CHR_BITS+SLOT_OFF_W-1:0]    chr_rom_addr,
  output logic                              chr_rom_en,
  output logic                              nt_a10
);
  localparam int PRG_AW = PRG16_BITS + 14;

  wsel_t                             wsel;
  logic [PRG16_BITS-1:0]             prg16_bank;
  logic [PRG16_BITS:0]               prg8_bank;
  logic [CHR_SLOTS-1:0][CHR_BITS-1:0] chr_bank;
  mirror_t                           mirror;

  mapper_reg_decode u_decode (
    .cpu_addr     (cpu_addr),
    .cpu_we       (cpu_we),
    .variant_swap (variant_swap),
    .wsel         (wsel)
  );

  mapper_bank_regs #(.PRG16_BITS(PRG16_BITS), .CHR_BITS(CHR_BITS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wsel       (wsel),
    .wdata      (cpu_data),
    .prg16_bank (prg16_bank),
    .prg8_bank  (prg8_bank),
    .chr_bank   (chr_bank),
    .mirror     (mirror)
  );

  mapper_addr_xlate #(.PRG16_BITS(PRG16_BITS), .CHR_BITS(CHR_BITS)) u_xlate (
    .cpu_addr     (cpu_addr),
    .ppu_addr     (ppu_addr),
    .prg16_bank   (prg16_bank),
    .prg8_bank    (prg8_bank),
    .chr_bank     (chr_bank),
    .mirror       (mirror),
    .prg_rom_addr (prg_rom_addr),
    .prg_rom_en   (prg_rom_en),
    .prg_ram_en   (prg_ram_en),
    .chr_rom_addr (chr_rom_addr),
    .chr_rom_en   (chr_rom_en),
    .nt_a10       (nt_a10)
  );

  // R8: a single write never reaches two registers
  p_sel_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel));
  // R4: the top window always points at the last bank
  p_fixed_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> (prg_rom_addr[PRG_AW-1:13] == '1));
  // R7: single-screen lower mode drives A10 low
  p_a10_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mirror == MIR_LOW) |-> !nt_a10);
  // R5: RAM and ROM selects are exclusive
  p_ram_rom_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(prg_ram_en && prg_rom_en));
endmodule

// File: tb/tb_bank_mapper.sv
`timescale 1ns/1ps
module tb_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_we = 1'b0;
  logic        variant_swap = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic [17:0] prg_rom_addr;
  logic        prg_rom_en, prg_ram_en, chr_rom_en, nt_a10;
  logic [17:0] chr_rom_addr;

  always #10 clk = ~clk;

  bank_mapper dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_we(cpu_we), .variant_swap(variant_swap), .ppu_addr(ppu_addr),
    .prg_rom_addr(prg_rom_addr), .prg_rom_en(prg_rom_en), .prg_ram_en(prg_ram_en),
    .chr_rom_addr(chr_rom_addr), .chr_rom_en(chr_rom_en), .nt_a10(nt_a10)
  );

  typedef struct {
    string       tag;
    int          kind;
    logic [17:0] exp;
  } item_t;

  item_t q[$];
  event  ev;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  logic [3:0] m_prg16;
  logic [4:0] m_prg8;
  logic [1:0] m_mir;
  logic [7:0] m_chr [8];

  // monitor: compares outputs against queued expectations
  initial forever begin
    @(ev);
    while (q.size() > 0) begin
      item_t       it;
      logic [17:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = prg_rom_addr;
        1: act = chr_rom_addr;
        2: act = {17'b0, nt_a10};
        3: act = {17'b0, prg_ram_en};
        4: act = {17'b0, prg_rom_en};
        default: act = {17'b0, chr_rom_en};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_now(input string tag, input int kind, input logic [17:0] e);
    q.push_back('{tag, kind, e});
    ->ev;
    #1;
  endtask

  task automatic cpu_probe(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a;
    #5;
  endtask

  task automatic ppu_probe(input logic [13:0] a);
    @(negedge clk);
    ppu_addr = a;
    #5;
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    cpu_data = d;
    cpu_we   = 1'b1;
    @(negedge clk);
    cpu_we   = 1'b0;
  endtask

  function automatic logic a10_model(input logic [1:0] mode, input logic [13:0] pa);
    case (mode)
      2'd0: return pa[10];
      2'd1: return pa[11];
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check_state(input string tag);
    cpu_probe(16'h9357);
    expect_now({tag, " R2 window16"}, 0, {m_prg16, 14'h1357});
    cpu_probe(16'hCABC);
    expect_now({tag, " R3 window8"}, 0, {m_prg8, 13'h0ABC});
    for (int i = 0; i < 8; i++) begin
      logic [13:0] pa;
      pa = 14'(i * 1024 + 'h2B5);
      ppu_probe(pa);
      expect_now($sformatf("%s R6 slot%0d", tag, i), 1, {m_chr[i], 10'h2B5});
    end
    ppu_probe(14'h2400);
    expect_now({tag, " R7 a10@2400"}, 2, {17'b0, a10_model(m_mir, 14'h2400)});
    ppu_probe(14'h2800);
    expect_now({tag, " R7 a10@2800"}, 2, {17'b0, a10_model(m_mir, 14'h2800)});
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_prg16 = '0; m_prg8 = '0; m_mir = '0;
    for (int i = 0; i < 8; i++) m_chr[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_state("R1 reset");

    // R2: 16 KB bank, upper data bits dropped
    cpu_write(16'h8000, 8'hF6); m_prg16 = 4'h6;
    cpu_probe(16'hA001);
    expect_now("R2 bank6", 0, {4'h6, 14'h2001});

    // R3: 8 KB bank
    cpu_write(16'hC002, 8'hE9); m_prg8 = 5'h09;
    cpu_probe(16'hD000);
    expect_now("R3 bank9", 0, {5'h09, 13'h1000});

    // R4: fixed last bank
    cpu_probe(16'hFFFC);
    expect_now("R4 fixed top", 0, {5'h1F, 13'h1FFC});
    cpu_probe(16'hE000);
    expect_now("R4 fixed base", 0, {5'h1F, 13'h0000});

    // R5: enables at range edges
    cpu_probe(16'h5FFF);
    expect_now("R5 ram 5FFF", 3, 18'd0);
    expect_now("R5 rom 5FFF", 4, 18'd0);
    cpu_probe(16'h6000);
    expect_now("R5 ram 6000", 3, 18'd1);
    cpu_probe(16'h7FFF);
    expect_now("R5 ram 7FFF", 3, 18'd1);
    expect_now("R5 rom 7FFF", 4, 18'd0);
    cpu_probe(16'h8000);
    expect_now("R5 ram 8000", 3, 18'd0);
    expect_now("R5 rom 8000", 4, 18'd1);

    // R6: all eight character slots
    for (int i = 0; i < 8; i++) begin
      logic [15:0] wa;
      wa = (i < 4 ? 16'hD000 : 16'hE000) + 16'(i % 4);
      m_chr[i] = 8'(8'h10 + i * 8'h11);
      cpu_write(wa, m_chr[i]);
    end
    check_state("R6 slots");
    ppu_probe(14'h1FFF);
    expect_now("R6 chr_en 1FFF", 5, 18'd1);
    ppu_probe(14'h2000);
    expect_now("R6 chr_en 2000", 5, 18'd0);

    // R7: the four mirroring modes
    for (int m = 1; m < 4; m++) begin
      cpu_write(16'hB003, 8'(m << 2)); m_mir = 2'(m);
      ppu_probe(14'h2400);
      expect_now($sformatf("R7 mode%0d 2400", m), 2, {17'b0, a10_model(m_mir, 14'h2400)});
      ppu_probe(14'h2C00);
      expect_now($sformatf("R7 mode%0d 2C00", m), 2, {17'b0, a10_model(m_mir, 14'h2C00)});
      ppu_probe(14'h2800);
      expect_now($sformatf("R7 mode%0d 2800", m), 2, {17'b0, a10_model(m_mir, 14'h2800)});
    end
    cpu_write(16'hB003, 8'h04); m_mir = 2'd1;

    // R8: address mask aliases
    cpu_write(16'hDE6A, 8'h77); m_chr[2] = 8'h77;
    cpu_write(16'h8FFF, 8'h03); m_prg16 = 4'h3;
    cpu_write(16'hBFF7, 8'h08); m_mir = 2'd2;
    check_state("R8 alias");
    cpu_write(16'hB003, 8'h04); m_mir = 2'd1;

    // R9: strap swaps offsets 1 and 2
    variant_swap = 1'b1;
    cpu_write(16'hD001, 8'hA1); m_chr[2] = 8'hA1;
    cpu_write(16'hD002, 8'hB2); m_chr[1] = 8'hB2;
    cpu_write(16'hE001, 8'hC6); m_chr[6] = 8'hC6;
    cpu_write(16'hE003, 8'hD7); m_chr[7] = 8'hD7;
    check_state("R9 swapped");
    variant_swap = 1'b0;

    // R10: writes to other pages leave all registers alone
    cpu_write(16'h9003, 8'hFF);
    cpu_write(16'hA000, 8'hFF);
    cpu_write(16'hB000, 8'hFF);
    cpu_write(16'hB001, 8'hFF);
    cpu_write(16'hB002, 8'hFF);
    cpu_write(16'hF000, 8'hFF);
    cpu_write(16'hF001, 8'hFF);
    cpu_write(16'hF002, 8'hFF);
    cpu_write(16'h6000, 8'hFF);
    cpu_write(16'h1000, 8'hFF);
    check_state("R10 ignored");

    // R11: strobe low has no effect
    @(negedge clk);
    cpu_addr = 16'h8000; cpu_data = 8'h0C;
    repeat (3) @(negedge clk);
    #5;
    expect_now("R11 strobe low", 0, {m_prg16, 14'h0});
    // R11: value changes only at the strobed edge
    @(negedge clk);
    cpu_we = 1'b1;
    #5;
    expect_now("R11 before edge", 0, {m_prg16, 14'h0});
    @(posedge clk);
    #5;
    expect_now("R11 after edge", 0, {4'hC, 14'h0});
    m_prg16 = 4'hC;
    @(negedge clk);
    cpu_we = 1'b0;
    check_state("R11 final");

    #20;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule